// File: doc/BRIEF.md
# Power-Save Clock Divider Control Register

This block holds a 16-bit system configuration word and turns part of it into clock control. When the power-save enable is set, the internal operating clock is slowed by a power of two taken from a 3-bit field. The slowed clock is produced as a one-cycle enable pulse at the chosen rate. Any hardware interrupt clears the enable by itself, whether it comes from an external pin or from an on-chip peripheral. Software interrupts and exceptions leave the enable alone, and nothing restores it when the interrupt routine returns.

A second control bit chooses what the clock-output indicator follows: the undivided input clock or the divided internal clock. Three more bits select chip-select, strobe and demodulation modes for logic outside this block. Here they are only stored. Bits with no function are stored too. A new divisor or enable value takes effect only at the divider's next terminal count, so a divided-clock period is never cut short.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the register reads 0000h, and `clk_en_o` is high on every cycle (divide by 1).
- R2: With bit 15 = 1, `clk_en_o` pulses once every 2^d cycles, where d is the value of bits 2:0 (000 = /1, 001 = /2, and so on up to 111 = /128).
- R3: A pulse on `hw_irq_i` clears bit 15 on the next clock edge and leaves all other bits unchanged.
- R4: A pulse on `sw_irq_i` changes no register bit and does not change the divided-clock period.
- R5: Once bit 15 has been cleared by a hardware interrupt, it stays 0 until software writes it again.
- R6: If a write that sets bit 15 happens in the same cycle as `hw_irq_i`, bit 15 ends up 0 and every other written bit is stored.
- R7: With bit 11 = 1, `clkout_en_o` is high on every cycle. With bit 11 = 0, `clkout_en_o` equals `clk_en_o`.
- R8: A write stores all 16 bits, including bits 14, 13 and 12 and the bits with no function, and a read returns them exactly as written.
- R9: A divisor change made in the middle of a divided period takes effect only after the current period has run its full length.
- R10: Clearing the enable in the middle of a divided period, whether by interrupt or by write, also waits for the current period's terminal count before `clk_en_o` goes back to every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| hw_irq_i | input | 1 | Hardware interrupt pulse (external or peripheral) |
| sw_irq_i | input | 1 | Software interrupt or exception pulse |
| rd_data_o | output | 16 | Register read data |
| clk_en_o | output | 1 | Divided internal clock enable pulse |
| clkout_en_o | output | 1 | Clock-output indicator, following the selected source |

## Verification
The bench measures the gap between consecutive `clk_en_o` pulses for all eight divisor codes. A divider with an off-by-one terminal count, or with swapped codes, shows up as a wrong gap. It changes the divisor, and clears the enable by interrupt, one cycle after a pulse. A design that applied the new setting at once would produce a short period, where the correct result is the full old one. It fires a write and an interrupt in the same cycle, and checks that other bits survive an interrupt clear. This catches a design where the write overrides the clear, or where the clear wipes the whole word. It also checks that a software interrupt disturbs neither the stored word nor the period.

// File: rtl/pwrclk_pkg.sv
package pwrclk_pkg;
  localparam int REG_W   = 16;
  localparam int DIV_W   = 3;
  localparam int EN_BIT  = 15;
  localparam int SRC_BIT = 11;
  localparam int DIV_LSB = 0;
  // counter must reach 2**(2**DIV_W-1)-1
  localparam int CNT_W   = (2 ** DIV_W) - 1;
  localparam logic [REG_W-1:0] EN_MASK = REG_W'(1) << EN_BIT;
endpackage

// File: rtl/pcfg_regfile.sv
module pcfg_regfile
  import pwrclk_pkg::*;
#(
  parameter int W   = REG_W,
  parameter int ENB = EN_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         hw_irq_i,
  output logic [W-1:0] cfg_q_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (wr_en_i) cfg_q <= wr_data_i;
      // interrupt clear overrides a same-cycle write
      if (hw_irq_i) cfg_q[ENB] <= 1'b0;
    end
  end

  assign cfg_q_o = cfg_q;
endmodule

// File: rtl/pcfg_divider.sv
module pcfg_divider
  import pwrclk_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic          act_en_q;
  logic [DW-1:0] act_div_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          term;

  always_comb begin
    limit = '0;
    for (int i = 0; i < CW; i++) begin
      if (act_en_q && (i < int'(act_div_q))) limit[i] = 1'b1;
    end
  end

  assign term = (cnt_q == limit);

  // settings are sampled only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_en_q  <= 1'b0;
      act_div_q <= '0;
    end else if (term) begin
      cnt_q     <= '0;
      act_en_q  <= en_i;
      act_div_q <= div_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = term;
endmodule

// File: rtl/pcfg_clkout.sv
module pcfg_clkout (
  input  logic src_sel_i,
  input  logic tick_i,
  output logic clkout_o
);
  assign clkout_o = src_sel_i ? 1'b1 : tick_i;
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwrclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             hw_irq_i,
  input  logic             sw_irq_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             clk_en_o,
  output logic             clkout_en_o
);
  logic [REG_W-1:0] cfg_q;

  pcfg_regfile #(.W(REG_W), .ENB(EN_BIT)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .hw_irq_i  (hw_irq_i),
    .cfg_q_o   (cfg_q)
  );

  pcfg_divider #(.DW(DIV_W), .CW(CNT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_q[EN_BIT]),
    .div_i  (cfg_q[DIV_LSB +: DIV_W]),
    .tick_o (clk_en_o)
  );

  pcfg_clkout u_out (
    .src_sel_i (cfg_q[SRC_BIT]),
    .tick_i    (clk_en_o),
    .clkout_o  (clkout_en_o)
  );

  // software interrupts and exceptions do not touch the register
  logic unused_sw;
  assign unused_sw = sw_irq_i;
  assign rd_data_o = cfg_q;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk
  import pwrclk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             hw_irq_i,
  input logic             sw_irq_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             clk_en_o,
  input logic             clkout_en_o
);
  localparam int MAX_GAP = 2 ** CNT_W;
  localparam int GW = CNT_W + 1;

  logic          seen_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      gap_q  <= clk_en_o ? '0 : gap_q + 1'b1;
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (rd_data_o == '0));

  assert_gap_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(gap_q) < MAX_GAP);

  assert_irq_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_irq_i |=> !rd_data_o[EN_BIT]);

  assert_sw_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_irq_i && !hw_irq_i && !wr_en_i) |=> $stable(rd_data_o));

  assert_irq_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hw_irq_i) |=> (rd_data_o == ($past(wr_data_i) & ~EN_MASK)));

  assert_src_fast_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[SRC_BIT] |-> clkout_en_o);

  assert_src_div_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[SRC_BIT] |-> (clkout_en_o == clk_en_o));

  assert_write_back_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hw_irq_i) |=> (rd_data_o == $past(wr_data_i)));
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk u_chk (.*);

// File: tb/sim_pwr_clk_ctrl.sv
module sim_pwr_clk_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        hw_irq = 1'b0;
  logic        sw_irq = 1'b0;
  logic [15:0] rd_data;
  logic        clk_en;
  logic        clkout_en;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_clk_ctrl u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .hw_irq_i    (hw_irq),
    .sw_irq_i    (sw_irq),
    .rd_data_o   (rd_data),
    .clk_en_o    (clk_en),
    .clkout_en_o (clkout_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input bit irq = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; hw_irq = irq;
    @(negedge clk);
    wr_en = 1'b0; hw_irq = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!clk_en);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_en);
  endtask

  task automatic t_reset();
    int cnt = 0;
    chk("R1", "reset value", int'(rd_data), 0);
    for (int i = 0; i < 8; i++) begin
      if (clk_en && clkout_en) cnt++;
      @(negedge clk);
    end
    chk("R1", "undivided pulses", cnt, 8);
  endtask

  task automatic t_divisors();
    int g;
    for (int d = 0; d < 8; d++) begin
      wr(16'h8000 | 16'(d));
      wait_pulse();
      measure(g);
      chk("R2", $sformatf("period code %0d", d), g, 1 << d);
    end
  endtask

  task automatic t_irq_clear();
    wr(16'h8A05);
    @(negedge clk); hw_irq = 1'b1;
    @(negedge clk); hw_irq = 1'b0;
    chk("R3", "irq clears enable only", int'(rd_data), 16'h0A05);
    repeat (20) @(negedge clk);
    chk("R5", "enable not restored", int'(rd_data), 16'h0A05);
  endtask

  task automatic t_sw_irq();
    int g;
    wr(16'h8003);
    @(negedge clk); sw_irq = 1'b1;
    @(negedge clk); sw_irq = 1'b0;
    chk("R4", "sw irq keeps register", int'(rd_data), 16'h8003);
    wait_pulse();
    measure(g);
    chk("R4", "sw irq keeps period", g, 8);
  endtask

  task automatic t_collision();
    int g;
    wr(16'hF0F7, 1'b1);
    chk("R6", "irq wins over write", int'(rd_data), 16'h70F7);
    wait_pulse();
    measure(g);
    chk("R6", "divider stays off", g, 1);
  endtask

  task automatic t_clkout();
    int c = 0;
    int t = 0;
    int bad = 0;
    wr(16'h0800);
    for (int i = 0; i < 16; i++) begin
      if (clkout_en) c++;
      @(negedge clk);
    end
    chk("R7", "fast source undivided", c, 16);
    wr(16'h8805);
    wait_pulse();
    c = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clkout_en) c++;
      if (clk_en) t++;
    end
    chk("R7", "fast source while /32", c, 32);
    chk("R7", "divided ticks while /32", t, 1);
    wr(16'h8002);
    wait_pulse();
    t = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (clkout_en != clk_en) bad++;
      if (clk_en) t++;
    end
    chk("R7", "output follows divided", bad, 0);
    chk("R7", "divided ticks /4", t, 4);
  endtask

  task automatic t_storage();
    wr(16'h7FF8);
    chk("R8", "readback 7ff8", int'(rd_data), 16'h7FF8);
    wr(16'h5555);
    chk("R8", "readback 5555", int'(rd_data), 16'h5555);
    wr(16'h0000);
    chk("R8", "readback 0000", int'(rd_data), 0);
  endtask

  task automatic t_midchange();
    int g;
    int n = 0;
    int early = 0;
    wr(16'h8003);
    wait_pulse();
    measure(g);
    @(negedge clk); n++; if (clk_en && early == 0) early = n;
    wr_en = 1'b1; wr_data = 16'h8001;
    @(negedge clk); n++; if (clk_en && early == 0) early = n;
    wr_en = 1'b0;
    while (!clk_en) begin @(negedge clk); n++; end
    chk("R9", "old period completes", (early != 0) ? early : n, 8);
    measure(g);
    chk("R9", "new period applied", g, 2);
  endtask

  task automatic t_midclear();
    int g;
    int n = 0;
    int early = 0;
    wr(16'h8004);
    wait_pulse();
    measure(g);
    @(negedge clk); n++; if (clk_en && early == 0) early = n;
    hw_irq = 1'b1;
    @(negedge clk); n++; if (clk_en && early == 0) early = n;
    hw_irq = 1'b0;
    chk("R3", "enable cleared mid-period", int'(rd_data[15]), 0);
    while (!clk_en) begin @(negedge clk); n++; end
    chk("R10", "period finishes after clear", (early != 0) ? early : n, 16);
    measure(g);
    chk("R10", "undivided after clear", g, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_divisors();
    t_irq_clear();
    t_sw_irq();
    t_collision();
    t_clkout();
    t_storage();
    t_midchange();
    t_midclear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule